// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block sits inside a memory controller and decides, row by row, when each DRAM row gets a refresh command. Rather than refreshing every row at the rate the weakest cell demands, rows are sorted into three retention classes. Two Bloom filters record which rows are weak. The fast filter holds rows that retain data for 64 to 128 ms. The middle filter holds rows that retain data for 128 to 256 ms. Every other row falls into the slow default class. A filter can answer that a row is present when it was never inserted. The only cost of such a false hit is an extra refresh. A filter never misses a row that was inserted, so no row is refreshed too rarely.

A row index sweeps every row once per base period (64 ms at the default parameters). A free-running slot timer spaces the row visits evenly across that period, and a two-bit period counter records where the sweep stands in a four-period cycle. At each row slot the block probes both filters. From the result it picks the class and decides whether the row is due in the current period. A due row is offered on a valid/ready request port; a row that is not due is passed over silently. Software or a profiling engine fills the filters through a small configuration port that supports insert, membership test and clear-all, one filter at a time.

Top module: `rrs_refresh_sched`

## Requirements
- R1: After reset, ref_valid and cfg_rsp_valid are low, the period counter is 0, and the first row offered is row 0.
- R2: After an insert of a row into a filter (cfg_op 0, cfg_sel 0 = fast filter, 1 = middle filter), a test of that row on that filter reports a hit: no false negatives.
- R3: A clear-all (cfg_op 2) empties only the selected filter. Afterwards every row tests as a miss on that filter, and rows held in the other filter still hit.
- R4: A test (cfg_op 1) gives exactly one cfg_rsp_valid pulse, in the cycle after the request. Insert, clear and the unused code 3 give no response.
- R5: Rows are visited in ascending order, wrapping from the last row to row 0. The period counter advances by one, modulo 4, on each wrap. In period 0 every row is offered, in order.
- R6: A row that hits the fast filter is offered in every period with ref_bin 0. The fast filter takes priority over the middle filter.
- R7: A row that hits only the middle filter is offered only in periods whose count modulo 4 is 0 or 2, with ref_bin 1.
- R8: A row that hits neither filter is offered only in periods whose count modulo 4 is 0, with ref_bin 2. Rows that are not due produce no request.
- R9: While ref_valid is high and ref_ready low, ref_valid, ref_row and ref_bin hold steady. The row index does not advance until the request is accepted.
- R10: With ref_ready held high, due rows are accepted exactly SLOT_CYCLES cycles apart.
- R11: Slot ticks that fall while a request is stalled merge into one owed slot. The next row is probed in the cycle after acceptance, so its request is accepted two cycles after the stalled one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_op | input | 2 | 0 insert, 1 test, 2 clear-all, 3 unused |
| cfg_sel | input | 1 | Target filter: 0 fast, 1 middle |
| cfg_row | input | ROW_W | Row address for insert or test |
| cfg_rsp_valid | output | 1 | Test result valid, one cycle after a test |
| cfg_rsp_hit | output | 1 | Test result: row present in the selected filter |
| ref_valid | output | 1 | Refresh request pending |
| ref_ready | input | 1 | Refresh request accepted when high with ref_valid |
| ref_row | output | ROW_W | Row to refresh |
| ref_bin | output | 2 | Retention class: 0 fast, 1 middle, 2 slow |

## Verification
The hardest case to reach is the owed-slot path: a due row stalled across several slot ticks, with the next due row probed straight after acceptance instead of at the next tick. The bench creates it in the second all-due period. It waits for a chosen grant index, holds ref_ready low for three slot lengths, then releases it and measures the gap between the next two grants. Expected rates come from membership answers read back through the test port, so hash false positives cannot mislead the scoreboard.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [1:0] {
        OP_INSERT = 2'd0,
        OP_TEST   = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_NONE   = 2'd3
    } cfg_op_e;

    typedef enum logic [1:0] {
        BIN_FAST = 2'd0,
        BIN_MID  = 2'd1,
        BIN_SLOW = 2'd2
    } bin_e;

    localparam int NUM_FILT = 2;
    localparam int MAX_HASH = 4;

endpackage

// File: rtl/rrs_hash.sv
module rrs_hash #(
    parameter int ROW_W    = 14,
    parameter int IDX_W    = 11,
    parameter int NUM_HASH = 3
) (
    input  logic [ROW_W-1:0]                row,
    output logic [NUM_HASH-1:0][IDX_W-1:0]  idx
);
    for (genvar k = 0; k < NUM_HASH; k++) begin : g_fn
        localparam logic [31:0] MULT = (32'h9E3779B1 + 32'(k) * 32'h6A09E667) | 32'h1;
        localparam int          ROT  = 3 + 7 * k;
        logic [31:0] word_w;
        logic [31:0] prod_w;
        logic [31:0] rot_w;
        always_comb begin
            word_w = 32'(row);
            prod_w = word_w * MULT;
            rot_w  = (prod_w << ROT) | (prod_w >> (32 - ROT));
            idx[k] = IDX_W'(rot_w ^ (rot_w >> (32 - IDX_W)));
        end
    end
endmodule

// File: rtl/rrs_bloom.sv
module rrs_bloom #(
    parameter int ROW_W     = 14,
    parameter int FILT_BITS = 2048,
    parameter int NUM_HASH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic             clr_en,
    input  logic [ROW_W-1:0] cfg_row,
    input  logic [ROW_W-1:0] probe_row,
    output logic             probe_hit,
    output logic             query_hit
);
    localparam int IDX_W = $clog2(FILT_BITS);

    typedef struct packed {
        logic [FILT_BITS-1:0] bits;
    } bloom_st_t;

    bloom_st_t st_d, st_q;

    logic [NUM_HASH-1:0][IDX_W-1:0] cfg_idx;
    logic [NUM_HASH-1:0][IDX_W-1:0] probe_idx;

    rrs_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_cfg_hash (
        .row (cfg_row),
        .idx (cfg_idx)
    );

    rrs_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_probe_hash (
        .row (probe_row),
        .idx (probe_idx)
    );

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.bits = '0;
        end else if (ins_en) begin
            for (int k = 0; k < NUM_HASH; k++) begin
                st_d.bits[cfg_idx[k]] = 1'b1;
            end
        end
        probe_hit = 1'b1;
        query_hit = 1'b1;
        for (int k = 0; k < NUM_HASH; k++) begin
            probe_hit = probe_hit & st_q.bits[probe_idx[k]];
            query_hit = query_hit & st_q.bits[cfg_idx[k]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < NUM_HASH; k++) begin : g_chk
        AST_INSERT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (ins_en && !clr_en) |=> st_q.bits[$past(cfg_idx[k])]); // R2
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !query_hit && !probe_hit); // R3
endmodule

// File: rtl/rrs_refresh_sched.sv
module rrs_refresh_sched
    import rrs_pkg::*;
#(
    parameter int ROW_W       = 14,
    parameter int FILT_BITS   = 2048,
    parameter int NUM_HASH    = 3,
    parameter int SLOT_CYCLES = 3906
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [1:0]       cfg_op,
    input  logic             cfg_sel,
    input  logic [ROW_W-1:0] cfg_row,
    output logic             cfg_rsp_valid,
    output logic             cfg_rsp_hit,
    output logic             ref_valid,
    input  logic             ref_ready,
    output logic [ROW_W-1:0] ref_row,
    output logic [1:0]       ref_bin
);
    localparam int                TMR_W      = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [TMR_W-1:0]  TMR_RELOAD = TMR_W'(SLOT_CYCLES - 1);
    localparam logic [ROW_W-1:0]  ROW_LAST   = '1;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [1:0]       period;
        logic [TMR_W-1:0] timer;
        logic             pend;
        logic             owed;
        logic [ROW_W-1:0] req_row;
        logic [1:0]       req_bin;
        logic             rsp_valid;
        logic             rsp_hit;
    } sched_st_t;

    sched_st_t st_d, st_q;

    cfg_op_e              op;
    logic [NUM_FILT-1:0]  ins_en;
    logic [NUM_FILT-1:0]  clr_en;
    logic [NUM_FILT-1:0]  probe_hit;
    logic [NUM_FILT-1:0]  query_hit;
    logic                 tick;
    logic                 accept;
    logic                 start;
    logic                 advance;
    logic                 due;
    bin_e                 bin;

    assign op = cfg_op_e'(cfg_op);

    for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
        assign ins_en[f] = cfg_valid && (op == OP_INSERT) && (cfg_sel == f[0]);
        assign clr_en[f] = cfg_valid && (op == OP_CLEAR)  && (cfg_sel == f[0]);

        rrs_bloom #(
            .ROW_W     (ROW_W),
            .FILT_BITS (FILT_BITS),
            .NUM_HASH  (NUM_HASH)
        ) u_bloom (
            .clk       (clk),
            .rst_n     (rst_n),
            .ins_en    (ins_en[f]),
            .clr_en    (clr_en[f]),
            .cfg_row   (cfg_row),
            .probe_row (st_q.row),
            .probe_hit (probe_hit[f]),
            .query_hit (query_hit[f])
        );
    end

    // Class of the row under the index: fast filter wins over the middle one.
    always_comb begin
        if (probe_hit[0]) begin
            bin = BIN_FAST;
        end else if (probe_hit[1]) begin
            bin = BIN_MID;
        end else begin
            bin = BIN_SLOW;
        end
        unique case (bin)
            BIN_FAST: due = 1'b1;
            BIN_MID:  due = !st_q.period[0];
            default:  due = (st_q.period == 2'd0);
        endcase
    end

    always_comb begin
        st_d    = st_q;
        tick    = (st_q.timer == '0);
        accept  = st_q.pend && ref_ready;
        start   = !st_q.pend && (tick || st_q.owed);
        advance = 1'b0;

        st_d.timer = tick ? TMR_RELOAD : st_q.timer - 1'b1;

        if (st_q.pend) begin
            if (tick) begin
                st_d.owed = 1'b1;
            end
            if (accept) begin
                st_d.pend = 1'b0;
                advance   = 1'b1;
            end
        end else if (start) begin
            st_d.owed = st_q.owed && tick;
            if (due) begin
                st_d.pend    = 1'b1;
                st_d.req_row = st_q.row;
                st_d.req_bin = bin;
            end else begin
                advance = 1'b1;
            end
        end

        if (advance) begin
            st_d.row = st_q.row + 1'b1;
            if (st_q.row == ROW_LAST) begin
                st_d.period = st_q.period + 1'b1;
            end
        end

        st_d.rsp_valid = cfg_valid && (op == OP_TEST);
        st_d.rsp_hit   = cfg_sel ? query_hit[1] : query_hit[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.timer <= TMR_RELOAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_valid     = st_q.pend;
    assign ref_row       = st_q.req_row;
    assign ref_bin       = st_q.req_bin;
    assign cfg_rsp_valid = st_q.rsp_valid;
    assign cfg_rsp_hit   = st_q.rsp_hit;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && !ref_ready) |=> ref_valid && $stable(ref_row) && $stable(ref_bin)); // R9

    AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && !ref_ready) |=> $stable(st_q.row)); // R9

    AST_BIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> ref_bin != 2'd3); // R6

    AST_MID_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_bin == BIN_MID) |-> !st_q.period[0]); // R7

    AST_SLOW_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_bin == BIN_SLOW) |-> st_q.period == 2'd0); // R8

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.row != $past(st_q.row)) |-> st_q.row == $past(st_q.row) + 1'b1); // R5

    AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.period != $past(st_q.period)) |-> (st_q.row == '0) && ($past(st_q.row) == ROW_LAST)); // R5

    AST_RSP_AFTER_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rsp_valid |-> $past(cfg_valid) && ($past(cfg_op) == OP_TEST)); // R4

    AST_OWED_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_ready && st_q.owed) |=> !st_q.pend && (st_q.row == $past(st_q.row) + 1'b1)); // R11
endmodule

// File: tb/rrs_refresh_sched_test.sv
`timescale 1ns/1ps
module rrs_refresh_sched_test;
    localparam int ROW_W = 5;
    localparam int ROWS  = 1 << ROW_W;
    localparam int SLOT  = 8;
    localparam int LIMIT = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_valid = 1'b0;
    logic [1:0]       cfg_op = 2'd0;
    logic             cfg_sel = 1'b0;
    logic [ROW_W-1:0] cfg_row = '0;
    logic             cfg_rsp_valid;
    logic             cfg_rsp_hit;
    logic             ref_valid;
    logic             ref_ready = 1'b1;
    logic [ROW_W-1:0] ref_row;
    logic [1:0]       ref_bin;

    rrs_refresh_sched #(
        .ROW_W       (ROW_W),
        .FILT_BITS   (2048),
        .NUM_HASH    (3),
        .SLOT_CYCLES (SLOT)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_valid     (cfg_valid),
        .cfg_op        (cfg_op),
        .cfg_sel       (cfg_sel),
        .cfg_row       (cfg_row),
        .cfg_rsp_valid (cfg_rsp_valid),
        .cfg_rsp_hit   (cfg_rsp_hit),
        .ref_valid     (ref_valid),
        .ref_ready     (ref_ready),
        .ref_row       (ref_row),
        .ref_bin       (ref_bin)
    );

    always #4 clk = ~clk;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_fail = 0;
    int  gidx = 0;
    int  gcyc [0:511];
    bit  done = 1'b0;
    logic [ROW_W+1:0] exp_q [$];
    bit  hit_a [0:ROWS-1];
    bit  hit_b [0:ROWS-1];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > LIMIT && !done) begin
            done = 1'b1;
            check(1'b0, "R5 watchdog", cyc, LIMIT);
            finish_run();
        end
    end

    // Monitor: samples just before each rising edge, where a grant is about to happen.
    bit               hold_seen = 1'b0;
    logic [ROW_W-1:0] hold_row;
    logic [1:0]       hold_bin;
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n) begin
                if (hold_seen) begin
                    check(ref_valid && ref_row == hold_row && ref_bin == hold_bin,
                          "R9 hold", int'(ref_row), int'(hold_row));
                end
                hold_seen = ref_valid && !ref_ready;
                hold_row  = ref_row;
                hold_bin  = ref_bin;
                if (ref_valid && ref_ready) begin
                    gcyc[gidx] = cyc;
                    if (gidx < ROWS) begin
                        check(int'(ref_row) == gidx, (gidx == 0) ? "R1 first row" : "R5 order",
                              int'(ref_row), gidx);
                        if (gidx > 0) begin
                            check(gcyc[gidx] - gcyc[gidx-1] == SLOT, "R10 spacing",
                                  gcyc[gidx] - gcyc[gidx-1], SLOT);
                        end
                    end else if (exp_q.size() == 0) begin
                        check(1'b0, "R8 unexpected request", int'(ref_row), -1);
                    end else begin
                        logic [ROW_W+1:0] e;
                        e = exp_q.pop_front();
                        check({ref_row, ref_bin} == e,
                              (e[1:0] == 2'd0) ? "R6 fast" : (e[1:0] == 2'd1) ? "R7 mid" : "R8 slow",
                              int'({ref_row, ref_bin}), int'(e));
                    end
                    gidx++;
                end
            end
        end
    end

    task automatic cfg_do(input logic [1:0] op, input logic sel, input logic [ROW_W-1:0] row,
                          output logic hit);
        cfg_valid = 1'b1;
        cfg_op    = op;
        cfg_sel   = sel;
        cfg_row   = row;
        @(negedge clk);
        cfg_valid = 1'b0;
        check(cfg_rsp_valid == (op == 2'd1), "R4 response", int'(cfg_rsp_valid), int'(op == 2'd1));
        hit = cfg_rsp_hit;
    endtask

    initial begin
        int fast_rows [3] = '{3, 17, 30};
        int mid_rows  [4] = '{5, 9, 17, 22};
        int stall_k;
        int total;
        logic h;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ref_valid, "R1 ref_valid", int'(ref_valid), 0);
        check(!cfg_rsp_valid, "R1 cfg_rsp_valid", int'(cfg_rsp_valid), 0);

        foreach (fast_rows[i]) cfg_do(2'd0, 1'b0, ROW_W'(fast_rows[i]), h);
        foreach (mid_rows[i])  cfg_do(2'd0, 1'b1, ROW_W'(mid_rows[i]), h);
        cfg_do(2'd3, 1'b0, ROW_W'(3), h);

        for (int r = 0; r < ROWS; r++) begin
            cfg_do(2'd1, 1'b0, ROW_W'(r), h);
            hit_a[r] = h;
            cfg_do(2'd1, 1'b1, ROW_W'(r), h);
            hit_b[r] = h;
        end
        foreach (fast_rows[i]) check(hit_a[fast_rows[i]], "R2 fast member", int'(hit_a[fast_rows[i]]), 1);
        foreach (mid_rows[i])  check(hit_b[mid_rows[i]],  "R2 mid member",  int'(hit_b[mid_rows[i]]), 1);
        check(gidx < ROWS, "R5 setup inside period 0", gidx, ROWS);

        stall_k = 0;
        total   = ROWS;
        for (int p = 1; p <= 4; p++) begin
            if (p == 4) stall_k = total + 2;
            for (int r = 0; r < ROWS; r++) begin
                logic [1:0] b;
                bit d;
                b = hit_a[r] ? 2'd0 : hit_b[r] ? 2'd1 : 2'd2;
                d = (b == 2'd0) || (b == 2'd1 && (p % 2) == 0) || (p % 4) == 0;
                if (d) begin
                    exp_q.push_back({ROW_W'(r), b});
                    total++;
                end
            end
        end

        // Periods 1 to 3 with an irregular ready pattern, then a long stall in period 4.
        forever begin
            @(negedge clk);
            if (gidx >= stall_k) break;
            ref_ready = (cyc % 4) != 1;
        end
        ref_ready = 1'b0;
        repeat (3 * SLOT) @(negedge clk);
        check(ref_valid, "R9 pending during stall", int'(ref_valid), 1);
        ref_ready = 1'b1;
        while (gidx < stall_k + 2) @(negedge clk);
        check(gcyc[stall_k + 1] - gcyc[stall_k] == 2, "R11 owed slot",
              gcyc[stall_k + 1] - gcyc[stall_k], 2);

        while (gidx < total) @(negedge clk);
        check(exp_q.size() == 0, "R8 all expected seen", exp_q.size(), 0);

        cfg_do(2'd2, 1'b0, '0, h);
        for (int r = 0; r < ROWS; r++) begin
            cfg_do(2'd1, 1'b0, ROW_W'(r), h);
            check(!h, "R3 cleared", int'(h), 0);
        end
        cfg_do(2'd1, 1'b1, ROW_W'(5), h);
        check(h, "R3 other filter kept", int'(h), 1);

        done = 1'b1;
        finish_run();
    end
endmodule